// File: doc/BRIEF.md
# Burst Beat Address Generator

This block produces the byte address of every beat of a memory-mapped burst. A command pulse loads the start address, the beat count minus one, the log2 of the bytes per beat and the burst type. The block then keeps a beat index that moves forward once for each accepted data handshake. For the current beat it drives the beat byte address, and also a word address with the sub-word bits cleared, so a memory array of bus-width words can be indexed with it directly.

Three burst types are stepped. A fixed burst repeats its start address. An incrementing burst walks upward from the start address after aligning it to the beat size. A wrapping burst walks upward too, but it folds back into a window whose size is the total burst length. While a command is loaded, the block checks it and raises three error flags. One marks an incrementing burst that leaves its 4 KiB page. One marks a beat size wider than the data bus. One marks a wrapping burst with an illegal beat count. The flags hold their values until the next command.

Top module: `burst_beat_addr`

## Requirements
- R1: After reset, busy, beat_last, beat_idx, beat_addr, word_addr and all three error flags are zero.
- R2: A cycle with cmd_start high loads the command, sets beat_idx to 0 and raises busy at the next edge, and this takes priority over beat_adv in the same cycle.
- R3: While busy, beat_adv high at an edge adds one to beat_idx when beat_idx is below cmd_len. When beat_idx equals the loaded length, beat_adv clears busy and leaves beat_idx unchanged. beat_last is high exactly when busy and beat_idx equals the loaded length. beat_adv has no effect while busy is low.
- R4: Burst type code 0 (fixed), and the reserved code 3, drive the loaded start address unchanged on every beat.
- R5: Burst type code 1 (incrementing) drives ((addr >> size) + beat_idx) << size, modulo 2^ADDR_W.
- R6: Burst type code 2 (wrapping) with total T = (len + 1) << size drives the incrementing address, minus T when that address reaches or passes the upper boundary. The lower boundary is the start address with its bits below T cleared, and the upper boundary is that lower boundary plus T.
- R7: word_addr equals beat_addr with its low log2(DATA_BYTES) bits forced to zero.
- R8: err_page_cross is set for an incrementing burst when (len << size) plus addr[11:0] exceeds 4095; other burst types never set it.
- R9: err_size is set when the size field exceeds log2(DATA_BYTES).
- R10: err_wrap_len is set for a wrapping burst whose len is not 1, 3, 7 or 15; other burst types never set it.
- R11: The three error flags change only at a command load and hold their values across all beats and after the burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Load a new burst command |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Beats minus one |
| cmd_size | input | SIZE_W | log2 of bytes per beat |
| cmd_burst | input | 2 | Burst type: 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| beat_adv | input | 1 | Data handshake accepted for the current beat |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| word_addr | output | ADDR_W | beat_addr aligned down to the bus width |
| beat_idx | output | LEN_W | Index of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| busy | output | 1 | A burst is loaded and not yet completed |
| err_page_cross | output | 1 | Incrementing burst leaves its 4 KiB page |
| err_size | output | 1 | Beat size wider than the bus |
| err_wrap_len | output | 1 | Wrapping burst with an illegal beat count |

## Verification
On every cycle, the assertions check how the index steps and saturates, that a fixed burst holds its address, that an incrementing burst moves by exactly one beat size per handshake, that every legal wrapping address stays inside its window, and that the flags do not change between loads. The absolute values can only be shown by the bench's scenarios: the aligned first beat, the point where a wrapping burst folds back, the exact edge of the page-cross limit, and the priority of a new command over a pending handshake. The bench compares these with a reference that computes the wrap with a modulo, not with a subtract-on-compare.

// File: rtl/burst_beat_pkg.sv
package burst_beat_pkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_kind_e;

  localparam int unsigned PAGE_LG = 12;

endpackage

// File: rtl/bba_cmd_reg.sv
module bba_cmd_reg
  import burst_beat_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned BUS_LG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [SIZE_W-1:0] in_size,
  input  burst_kind_e       in_kind,
  output logic [ADDR_W-1:0] q_addr,
  output logic [LEN_W-1:0]  q_len,
  output logic [SIZE_W-1:0] q_size,
  output burst_kind_e       q_kind,
  output logic              q_err_page,
  output logic              q_err_size,
  output logic              q_err_wlen
);

  localparam int unsigned SPAN_W = LEN_W + (1 << SIZE_W) + 2;

  function automatic logic leaves_page(input logic [LEN_W-1:0] len,
                                       input logic [SIZE_W-1:0] size,
                                       input logic [PAGE_LG-1:0] offs);
    logic [SPAN_W-1:0] span;
    span = (SPAN_W'(len) << size) + SPAN_W'(offs);
    return span > SPAN_W'((1 << PAGE_LG) - 1);
  endfunction

  function automatic logic wrap_count_ok(input logic [LEN_W-1:0] len);
    return (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
           (len == LEN_W'(7)) || (len == LEN_W'(15));
  endfunction

  logic chk_page, chk_size, chk_wlen;

  always_comb begin
    chk_page = (in_kind == BURST_INCR) && leaves_page(in_len, in_size, in_addr[PAGE_LG-1:0]);
    chk_size = in_size > SIZE_W'(BUS_LG);
    chk_wlen = (in_kind == BURST_WRAP) && !wrap_count_ok(in_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr     <= '0;
      q_len      <= '0;
      q_size     <= '0;
      q_kind     <= BURST_FIXED;
      q_err_page <= 1'b0;
      q_err_size <= 1'b0;
      q_err_wlen <= 1'b0;
    end else if (load) begin
      q_addr     <= in_addr;
      q_len      <= in_len;
      q_size     <= in_size;
      q_kind     <= in_kind;
      q_err_page <= chk_page;
      q_err_size <= chk_size;
      q_err_wlen <= chk_wlen;
    end
  end

endmodule

// File: rtl/bba_beat_ctr.sv
module bba_beat_ctr #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] idx,
  output logic             busy,
  output logic             last,
  output logic             step_evt,
  output logic             done_evt
);

  always_comb begin
    last     = busy && (idx == len_q);
    step_evt = !load && adv && busy && !last;
    done_evt = !load && adv && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      idx  <= '0;
      busy <= 1'b1;
    end else if (step_evt) begin
      idx  <= idx + LEN_W'(1);
    end else if (done_evt) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/bba_addr_calc.sv
module bba_addr_calc
  import burst_beat_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned BUS_LG = 3
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  burst_kind_e       kind,
  input  logic [LEN_W-1:0]  idx,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic [ADDR_W:0]   wrap_lo,
  output logic [ADDR_W:0]   wrap_hi
);

  localparam int unsigned XW = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << BUS_LG) - ADDR_W'(1));

  function automatic logic [XW-1:0] stepped(input logic [ADDR_W-1:0] a,
                                            input logic [SIZE_W-1:0] s,
                                            input logic [LEN_W-1:0] i);
    logic [XW-1:0] units;
    units = {1'b0, a} >> s;
    return (units + XW'(i)) << s;
  endfunction

  function automatic logic [XW-1:0] wrap_total(input logic [LEN_W-1:0] l,
                                               input logic [SIZE_W-1:0] s);
    return (XW'(l) + XW'(1)) << s;
  endfunction

  function automatic logic [XW-1:0] folded(input logic [XW-1:0] linear,
                                           input logic [XW-1:0] hi,
                                           input logic [XW-1:0] total);
    return (linear >= hi) ? (linear - total) : linear;
  endfunction

  logic [XW-1:0] lin_addr;
  logic [XW-1:0] total;
  logic [XW-1:0] wrapped;

  always_comb begin
    lin_addr = stepped(base_addr, size, idx);
    total    = wrap_total(len, size);
    wrap_lo  = {1'b0, base_addr} & ~(total - XW'(1));
    wrap_hi  = wrap_lo + total;
    wrapped  = folded(lin_addr, wrap_hi, total);
    unique case (kind)
      BURST_INCR: beat_addr = lin_addr[ADDR_W-1:0];
      BURST_WRAP: beat_addr = wrapped[ADDR_W-1:0];
      default:    beat_addr = base_addr;
    endcase
    word_addr = beat_addr & WORD_MASK;
  end

endmodule

// File: rtl/burst_beat_addr.sv
module burst_beat_addr
  import burst_beat_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned SIZE_W     = 3,
  parameter int unsigned DATA_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [1:0]        cmd_burst,
  input  logic              beat_adv,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LEN_W-1:0]  beat_idx,
  output logic              beat_last,
  output logic              busy,
  output logic              err_page_cross,
  output logic              err_size,
  output logic              err_wrap_len
);

  localparam int unsigned BUS_LG = $clog2(DATA_BYTES);

  logic [ADDR_W-1:0] q_addr;
  logic [LEN_W-1:0]  q_len;
  logic [SIZE_W-1:0] q_size;
  burst_kind_e       q_kind;
  logic [ADDR_W:0]   wrap_lo;
  logic [ADDR_W:0]   wrap_hi;
  logic              step_evt;
  logic              done_evt;

  bba_cmd_reg #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .BUS_LG(BUS_LG)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_start),
    .in_addr   (cmd_addr),
    .in_len    (cmd_len),
    .in_size   (cmd_size),
    .in_kind   (burst_kind_e'(cmd_burst)),
    .q_addr    (q_addr),
    .q_len     (q_len),
    .q_size    (q_size),
    .q_kind    (q_kind),
    .q_err_page(err_page_cross),
    .q_err_size(err_size),
    .q_err_wlen(err_wrap_len)
  );

  bba_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_start),
    .adv     (beat_adv),
    .len_q   (q_len),
    .idx     (beat_idx),
    .busy    (busy),
    .last    (beat_last),
    .step_evt(step_evt),
    .done_evt(done_evt)
  );

  bba_addr_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .BUS_LG(BUS_LG)
  ) u_calc (
    .base_addr(q_addr),
    .len      (q_len),
    .size     (q_size),
    .kind     (q_kind),
    .idx      (beat_idx),
    .beat_addr(beat_addr),
    .word_addr(word_addr),
    .wrap_lo  (wrap_lo),
    .wrap_hi  (wrap_hi)
  );

endmodule

// File: rtl/burst_beat_addr_chk.sv
module burst_beat_addr_chk
  import burst_beat_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned SIZE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              beat_adv,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [LEN_W-1:0]  beat_idx,
  input logic              beat_last,
  input logic              busy,
  input logic              err_page_cross,
  input logic              err_size,
  input logic              err_wrap_len,
  input logic [ADDR_W-1:0] q_addr,
  input logic [LEN_W-1:0]  q_len,
  input logic [SIZE_W-1:0] q_size,
  input burst_kind_e       q_kind,
  input logic [ADDR_W:0]   wrap_lo,
  input logic [ADDR_W:0]   wrap_hi
);

  assert_load_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (beat_idx == '0) && busy);

  assert_index_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_adv && busy && !beat_last && !cmd_start) |=> beat_idx == $past(beat_idx) + LEN_W'(1));

  assert_index_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_adv && beat_last && !cmd_start) |=> ($stable(beat_idx) && !busy));

  assert_index_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_idx <= q_len);

  assert_fixed_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_kind == BURST_FIXED) |-> beat_addr == q_addr);

  assert_incr_stride_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_adv && busy && !beat_last && !cmd_start && q_kind == BURST_INCR)
      |=> beat_addr == $past(beat_addr) + (ADDR_W'(1) << q_size));

  assert_wrap_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_kind == BURST_WRAP && !err_wrap_len)
      |-> ({1'b0, beat_addr} >= wrap_lo) && ({1'b0, beat_addr} < wrap_hi));

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_start |=> $stable({err_page_cross, err_size, err_wrap_len}));

endmodule

bind burst_beat_addr burst_beat_addr_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_start     (cmd_start),
  .beat_adv      (beat_adv),
  .beat_addr     (beat_addr),
  .beat_idx      (beat_idx),
  .beat_last     (beat_last),
  .busy          (busy),
  .err_page_cross(err_page_cross),
  .err_size      (err_size),
  .err_wrap_len  (err_wrap_len),
  .q_addr        (q_addr),
  .q_len         (q_len),
  .q_size        (q_size),
  .q_kind        (q_kind),
  .wrap_lo       (wrap_lo),
  .wrap_hi       (wrap_hi)
);

// File: tb/test_burst_beat_addr.sv
`timescale 1ns/1ps
module test_burst_beat_addr;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int SIZE_W = 3;
  localparam int DBYTES = 8;
  localparam int BUSLG  = 3;
  localparam longint unsigned AMASK = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [SIZE_W-1:0] cmd_size = '0;
  logic [1:0] cmd_burst = '0;
  logic beat_adv = 1'b0;
  logic [ADDR_W-1:0] beat_addr, word_addr;
  logic [LEN_W-1:0] beat_idx;
  logic beat_last, busy, err_page_cross, err_size, err_wrap_len;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  burst_beat_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .DATA_BYTES(DBYTES))
  i_burst_beat_addr (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_burst(cmd_burst), .beat_adv(beat_adv),
    .beat_addr(beat_addr), .word_addr(word_addr), .beat_idx(beat_idx),
    .beat_last(beat_last), .busy(busy), .err_page_cross(err_page_cross),
    .err_size(err_size), .err_wrap_len(err_wrap_len)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned ref_addr(input longint unsigned a, input int len,
                                               input int size, input int kind, input int i);
    longint unsigned bytes, first, total, lo;
    bytes = 64'd1 << size;
    first = (a / bytes) * bytes;
    if (kind == 1) return (first + i * bytes) & AMASK;
    if (kind == 2) begin
      total = (len + 1) * bytes;
      lo = (a / total) * total;
      return (lo + ((first - lo + i * bytes) % total)) & AMASK;
    end
    return a;
  endfunction

  function automatic bit ref_page(input longint unsigned a, input int len, input int size, input int kind);
    return (kind == 1) && (((longint'(len) << size) + (a % 4096)) > 4095);
  endfunction

  function automatic bit ref_wlen(input int len, input int kind);
    return (kind == 2) && !(len == 1 || len == 3 || len == 7 || len == 15);
  endfunction

  task automatic load_cmd(input longint unsigned a, input int len, input int size, input int kind);
    cmd_start = 1'b1;
    cmd_addr  = a[ADDR_W-1:0];
    cmd_len   = LEN_W'(len);
    cmd_size  = SIZE_W'(size);
    cmd_burst = 2'(kind);
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic check_flags(input string tag, input longint unsigned a, input int len,
                             input int size, input int kind);
    check({tag, " R8 page flag"}, err_page_cross, ref_page(a, len, size, kind));
    check({tag, " R9 size flag"}, err_size, size > BUSLG);
    check({tag, " R10 wrap len flag"}, err_wrap_len, ref_wlen(len, kind));
  endtask

  task automatic run_burst(input longint unsigned a, input int len, input int size,
                           input int kind, input bit chk_addr);
    longint unsigned e;
    @(negedge clk);
    load_cmd(a, len, size, kind);
    check("R2 busy after load", busy, 1);
    check("R2 index after load", beat_idx, 0);
    check_flags("load", a, len, size, kind);
    for (int i = 0; i <= len; i++) begin
      e = ref_addr(a, len, size, kind, i);
      if (chk_addr) begin
        if (kind == 1)      check("R5 incr beat addr", beat_addr, e);
        else if (kind == 2) check("R6 wrap beat addr", beat_addr, e);
        else                check("R4 fixed beat addr", beat_addr, e);
        check("R7 word addr", word_addr, e & ~longint'(DBYTES - 1));
      end
      check("R3 index", beat_idx, i);
      check("R3 last flag", beat_last, i == len);
      beat_adv = 1'b1;
      @(negedge clk);
      beat_adv = 1'b0;
    end
    check("R3 busy clears after last", busy, 0);
    check("R3 index held at end", beat_idx, len);
    beat_adv = 1'b1;
    @(negedge clk);
    beat_adv = 1'b0;
    check("R3 adv ignored when idle", beat_idx, len);
    check("R3 last low when idle", beat_last, 0);
    check_flags("R11 after burst", a, len, size, kind);
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 last", beat_last, 0);
    check("R1 index", beat_idx, 0);
    check("R1 beat addr", beat_addr, 0);
    check("R1 word addr", word_addr, 0);
    check("R1 flags", {err_page_cross, err_size, err_wrap_len}, 0);
    rst_n = 1'b1;

    run_burst(64'h0000_1234, 3, 2, 0, 1);
    run_burst(64'h0000_1237, 2, 2, 3, 1);
    run_burst(64'h0000_2013, 4, 2, 1, 1);
    run_burst(64'h0000_1038, 3, 3, 2, 1);
    run_burst(64'h0000_103C, 15, 2, 2, 1);
    run_burst(64'hFFFF_FFF8, 2, 3, 1, 1);
    run_burst(64'h0000_0FC0, 7, 3, 1, 1);
    run_burst(64'h0000_0FC8, 7, 3, 1, 1);
    run_burst(64'h0000_0400, 1, 4, 1, 1);
    run_burst(64'h0000_0500, 5, 2, 2, 0);

    // R2: new command wins over a handshake in the same cycle
    @(negedge clk);
    load_cmd(64'h0000_3000, 7, 2, 1);
    beat_adv = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 index mid burst", beat_idx, 2);
    load_cmd(64'h0000_5004, 3, 2, 1);
    check("R2 start beats adv index", beat_idx, 0);
    check("R2 start beats adv addr", beat_addr, 64'h5004);
    beat_adv = 1'b0;
    @(negedge clk);
    check("R2 index stays at zero", beat_idx, 0);

    for (int n = 0; n < 60; n++) begin
      int kind, size, len;
      longint unsigned a;
      kind = int'($urandom_range(0, 3));
      size = int'($urandom_range(0, BUSLG + 1));
      a = longint'($urandom);
      if (kind == 2 && $urandom_range(0, 3) != 0) len = (2 << $urandom_range(0, 3)) - 1;
      else len = int'($urandom_range(0, 15));
      run_burst(a, len, size, kind, !ref_wlen(len, kind));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule